// File: doc/BRIEF.md
# Hard-Decision Bit-Flip Node Pair

This block holds the two node types of a hard-decision iterative decoder for a low-density parity-check code, side by side in one parameterised unit. The variable-node half takes one received channel bit and `DV` messages arriving from check nodes. It returns `DV` outgoing messages and a decision bit. Each outgoing edge uses an extrinsic unanimity vote that falls back to the channel bit. The check-node half takes `DC` bits from variable nodes. It returns, on each edge, the parity of every other input on that node.

The surrounding decoder owns the graph wiring and the code matrix. It pulses `start` to load a new channel bit and begin the first iteration. After that, each `iter_en` pulse advances one iteration. Every output is a register that changes only on those pulses, so a whole array of these units moves in lock step. The defaults are `DV = 3` and `DC = 6`. Both degrees must be at least 2.

Top module: `bf_node_pair`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, that edge clears `vn_out`, `vn_decision` and `cn_out` to all zeros, and it clears the stored channel bit to 0.
- R2: A rising edge with `start` high stores `chan_bit`. The same edge drives every bit of `vn_out`, and `vn_decision`, to that `chan_bit`.
- R3: A rising edge with `iter_en` high and `start` low sets `vn_out[k]` to 1 when every `vn_in` bit other than bit k is 1.
- R4: On such an iteration edge, `vn_out[k]` becomes 0 when every `vn_in` bit other than bit k is 0.
- R5: On such an iteration edge, when the other `vn_in` bits are mixed, `vn_out[k]` becomes the stored channel bit.
- R6: On such an iteration edge, `vn_decision` becomes the majority of the stored channel bit and all `DV` bits of `vn_in`. The vote counts `DV+1` bits, and a tied vote gives the stored channel bit.
- R7: A rising edge with `start` or `iter_en` high sets `cn_out[k]` to the XOR of every `cn_in` bit except bit k.
- R8: A rising edge with both `start` and `iter_en` low leaves `vn_out`, `vn_decision` and `cn_out` unchanged.
- R9: When `start` and `iter_en` are both high, `start` wins. The variable-node outputs follow R2, and the check node updates as in R7.
- R10: `chan_bit` is sampled only on `start` edges. A change in `chan_bit` at any other time has no effect on later fallback values or tie-breaks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Load channel bit; first iteration |
| iter_en | input | 1 | Advance one iteration |
| chan_bit | input | 1 | Received hard-decision channel bit |
| vn_in | input | DV | Messages from check nodes into the variable node |
| vn_out | output | DV | Extrinsic messages from the variable node |
| vn_decision | output | 1 | Current bit decision |
| cn_in | input | DC | Messages from variable nodes into the check node |
| cn_out | output | DC | Extrinsic parity messages from the check node |

## Verification
The bench targets several corner cases, each paired with the fault it would expose:
- Edges whose extrinsic set is unanimous while the edge's own input disagrees. A design that counted its own edge would flip these results.
- Ties in the four-way decision vote. A design that broke ties toward 0 or 1 instead of the channel bit would fail here.
- Cycles where `start` and `iter_en` are both high. A design that let the iteration win would emit computed messages instead of the channel copy.
- A change on `chan_bit` between starts, followed by mixed edges. A design that used the live pin rather than the stored bit would report the new value.
- Idle cycles and a mid-run reset, which catch registers that update without an enable or that do not clear.

// File: rtl/bf_pkg.sv
// Shared types for the bit-flip node pair.
// Assumes nothing beyond a single clock domain.
package bf_pkg;

    // Update kind applied to the variable-node registers on a clock edge.
    typedef enum logic [1:0] {
        UPD_HOLD = 2'd0,
        UPD_LOAD = 2'd1,
        UPD_STEP = 2'd2
    } upd_e;

    // Start outranks iteration; neither means hold.
    function automatic upd_e upd_select(input logic load, input logic step);
        if (load)      return UPD_LOAD;
        else if (step) return UPD_STEP;
        else           return UPD_HOLD;
    endfunction

endpackage

// File: rtl/bf_edge_rule.sv
// Extrinsic unanimity rule for one outgoing variable-node edge.
// Output is 1 if all inputs except edge K are 1, 0 if they are all 0,
// and the channel bit otherwise. Assumes DV >= 2 and K < DV.
module bf_edge_rule #(
    parameter int DV = 3,
    parameter int K  = 0
) (
    input  logic [DV-1:0] msgs,
    input  logic          chan,
    output logic          nxt
);
    localparam logic [DV-1:0] SELF = DV'(1) << K;

    logic others_one;
    logic others_zero;

    // Vote over the extrinsic set, with the channel bit as fallback.
    always_comb begin
        others_one  = &(msgs | SELF);
        others_zero = ~|(msgs & ~SELF);
        if (others_one)       nxt = 1'b1;
        else if (others_zero) nxt = 1'b0;
        else                  nxt = chan;
    end
endmodule

// File: rtl/bf_majority.sv
// Majority vote over N message bits plus a channel bit (N+1 votes).
// A tied vote returns the channel bit. Assumes N >= 1.
module bf_majority #(
    parameter int N = 3
) (
    input  logic [N-1:0] msgs,
    input  logic         chan,
    output logic         dec
);
    localparam int          CW  = $clog2(N + 2);
    localparam logic [CW:0] TOT = (CW + 1)'(N + 1);

    logic [CW-1:0] cnt;
    logic [CW:0]   dbl;

    // Count the ones among all votes.
    always_comb begin
        cnt = CW'(chan);
        for (int i = 0; i < N; i++) begin
            cnt = cnt + CW'(msgs[i]);
        end
    end

    // Compare twice the count with the number of votes; a tie goes to the channel.
    always_comb begin
        dbl = {cnt, 1'b0};
        if (dbl > TOT)      dec = 1'b1;
        else if (dbl < TOT) dec = 1'b0;
        else                dec = chan;
    end
endmodule

// File: rtl/bf_var_node.sv
// Hard-decision variable node: stores the channel bit on load and
// registers DV extrinsic messages plus a decision once per iteration.
// Assumes DV >= 2; upd comes from bf_pkg::upd_select.
module bf_var_node
    import bf_pkg::*;
#(
    parameter int DV = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  upd_e          upd,
    input  logic          chan_bit,
    input  logic [DV-1:0] msg_in,
    output logic [DV-1:0] msg_out,
    output logic          decision
);
    logic          chan_q;
    logic [DV-1:0] edge_nxt;
    logic          dec_nxt;

    // One rule instance per outgoing edge.
    for (genvar k = 0; k < DV; k++) begin : g_edge
        bf_edge_rule #(.DV(DV), .K(k)) u_rule (
            .msgs (msg_in),
            .chan (chan_q),
            .nxt  (edge_nxt[k])
        );
    end

    bf_majority #(.N(DV)) u_vote (
        .msgs (msg_in),
        .chan (chan_q),
        .dec  (dec_nxt)
    );

    // Channel bit is captured only on a load.
    always_ff @(posedge clk) begin
        if (!rst_n)                chan_q <= 1'b0;
        else if (upd == UPD_LOAD)  chan_q <= chan_bit;
    end

    // Message and decision registers: copy the channel on load, vote on a step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_out  <= '0;
            decision <= 1'b0;
        end else begin
            unique case (upd)
                UPD_LOAD: begin
                    msg_out  <= {DV{chan_bit}};
                    decision <= chan_bit;
                end
                UPD_STEP: begin
                    msg_out  <= edge_nxt;
                    decision <= dec_nxt;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/bf_chk_node.sv
// Check node: each output is the parity of all inputs except its own,
// registered when adv is high. Assumes DC >= 2.
module bf_chk_node #(
    parameter int DC = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic [DC-1:0] msg_in,
    output logic [DC-1:0] msg_out
);
    logic          total;
    logic [DC-1:0] ext_nxt;

    // Full parity minus each edge's own bit gives the extrinsic parity.
    always_comb begin
        total   = ^msg_in;
        ext_nxt = msg_in ^ {DC{total}};
    end

    // Output register advances with each iteration.
    always_ff @(posedge clk) begin
        if (!rst_n)   msg_out <= '0;
        else if (adv) msg_out <= ext_nxt;
    end
endmodule

// File: rtl/bf_node_pair.sv
// Top: one variable node and one check node sharing the iteration
// controls. start begins a codeword and outranks iter_en. Graph
// wiring between units lies outside this block.
module bf_node_pair
    import bf_pkg::*;
#(
    parameter int DV = 3,
    parameter int DC = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          iter_en,
    input  logic          chan_bit,
    input  logic [DV-1:0] vn_in,
    output logic [DV-1:0] vn_out,
    output logic          vn_decision,
    input  logic [DC-1:0] cn_in,
    output logic [DC-1:0] cn_out
);
    upd_e upd;
    logic cn_adv;

    // Decode the iteration controls once for both nodes.
    always_comb begin
        upd    = upd_select(start, iter_en);
        cn_adv = (upd != UPD_HOLD);
    end

    bf_var_node #(.DV(DV)) u_vn (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd      (upd),
        .chan_bit (chan_bit),
        .msg_in   (vn_in),
        .msg_out  (vn_out),
        .decision (vn_decision)
    );

    bf_chk_node #(.DC(DC)) u_cn (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (cn_adv),
        .msg_in  (cn_in),
        .msg_out (cn_out)
    );
endmodule

// File: rtl/bf_node_pair_chk.sv
// Checker for bf_node_pair. It sees only the top's ports and keeps its
// own copy of the stored channel bit. Bound to every bf_node_pair.
module bf_node_pair_chk #(
    parameter int DV = 3,
    parameter int DC = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          iter_en,
    input logic          chan_bit,
    input logic [DV-1:0] vn_in,
    input logic [DV-1:0] vn_out,
    input logic          vn_decision,
    input logic [DC-1:0] cn_in,
    input logic [DC-1:0] cn_out
);
    logic        ch_ref;
    logic        step;
    int unsigned ones_pre;

    // Reference copy of the channel bit, taken on start only.
    always_ff @(posedge clk) begin
        if (!rst_n)     ch_ref <= 1'b0;
        else if (start) ch_ref <= chan_bit;
    end

    // Iteration edge qualifier and vote count for the decision check.
    always_comb begin
        step     = iter_en && !start;
        ones_pre = $countones(vn_in) + (ch_ref ? 32'd1 : 32'd0);
    end

    p_load_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (vn_out == {DV{$past(chan_bit)}}) && (vn_decision == $past(chan_bit)));

    p_decision_r6: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> vn_decision == ((2 * $past(ones_pre) > DV + 1) ? 1'b1 :
                                 (2 * $past(ones_pre) < DV + 1) ? 1'b0 : $past(ch_ref)));

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !iter_en) |=> $stable(vn_out) && $stable(vn_decision) && $stable(cn_out));

    for (genvar k = 0; k < DV; k++) begin : g_vn
        localparam logic [DV-1:0] SELF = DV'(1) << k;

        p_all_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (step && ((vn_in | SELF) == '1)) |=> vn_out[k]);

        p_all_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (step && ((vn_in & ~SELF) == '0)) |=> !vn_out[k]);

        // Also covers R10: the fallback uses the start-time copy, not chan_bit.
        p_mixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (step && ((vn_in | SELF) != '1) && ((vn_in & ~SELF) != '0))
            |=> vn_out[k] == $past(ch_ref));
    end

    for (genvar k = 0; k < DC; k++) begin : g_cn
        localparam logic [DC-1:0] OTHERS = ~(DC'(1) << k);

        p_parity_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (start || iter_en) |=> cn_out[k] == ^($past(cn_in) & OTHERS));
    end
endmodule

bind bf_node_pair bf_node_pair_chk #(.DV(DV), .DC(DC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .iter_en     (iter_en),
    .chan_bit    (chan_bit),
    .vn_in       (vn_in),
    .vn_out      (vn_out),
    .vn_decision (vn_decision),
    .cn_in       (cn_in),
    .cn_out      (cn_out)
);

// File: tb/bf_node_pair_bench.sv
module bf_node_pair_bench;
    localparam int DV = 3;
    localparam int DC = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          iter_en = 1'b0;
    logic          chan_bit = 1'b0;
    logic [DV-1:0] vn_in = '0;
    logic [DC-1:0] cn_in = '0;
    logic [DV-1:0] vn_out;
    logic          vn_decision;
    logic [DC-1:0] cn_out;

    int checks = 0;
    int fails  = 0;

    // Model state
    logic          m_ch  = 1'b0;
    logic [DV-1:0] m_vn  = '0;
    logic          m_dec = 1'b0;
    logic [DC-1:0] m_cn  = '0;

    // Fields: [11] start, [10] iter_en, [9] chan_bit, [8:6] vn_in, [5:0] cn_in
    localparam logic [11:0] VEC [0:15] = '{
        12'b1_0_1_010_110100,
        12'b0_1_0_111_000001,
        12'b0_1_0_000_111111,
        12'b0_1_0_011_101010,
        12'b0_0_0_101_011111,
        12'b0_0_1_110_100000,
        12'b1_0_0_111_000000,
        12'b0_1_0_110_111110,
        12'b0_1_1_001_010101,
        12'b1_1_1_000_110011,
        12'b0_1_0_100_001100,
        12'b0_1_0_010_100001,
        12'b0_1_0_111_011011,
        12'b0_0_1_011_111000,
        12'b0_1_0_101_000111,
        12'b0_1_0_000_101101
    };

    bf_node_pair #(.DV(DV), .DC(DC)) u_bf_node_pair (
        .clk(clk), .rst_n(rst_n), .start(start), .iter_en(iter_en),
        .chan_bit(chan_bit), .vn_in(vn_in), .vn_out(vn_out),
        .vn_decision(vn_decision), .cn_in(cn_in), .cn_out(cn_out)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic ref_edge(input logic [DV-1:0] m, input int k, input logic ch);
        int ones = 0;
        for (int i = 0; i < DV; i++) if (i != k && m[i]) ones++;
        if (ones == DV - 1) return 1'b1;
        if (ones == 0)      return 1'b0;
        return ch;
    endfunction

    function automatic string edge_tag(input logic [DV-1:0] m, input int k);
        int ones = 0;
        for (int i = 0; i < DV; i++) if (i != k && m[i]) ones++;
        if (ones == DV - 1) return "R3";
        if (ones == 0)      return "R4";
        return "R5";
    endfunction

    function automatic logic ref_vote(input logic [DV-1:0] m, input logic ch);
        int ones = ch ? 1 : 0;
        for (int i = 0; i < DV; i++) if (m[i]) ones++;
        if (2 * ones > DV + 1) return 1'b1;
        if (2 * ones < DV + 1) return 1'b0;
        return ch;
    endfunction

    function automatic logic [DC-1:0] ref_parity(input logic [DC-1:0] m);
        logic [DC-1:0] r;
        for (int k = 0; k < DC; k++) begin
            r[k] = 1'b0;
            for (int i = 0; i < DC; i++) if (i != k) r[k] = r[k] ^ m[i];
        end
        return r;
    endfunction

    // One clock: drive at the falling edge, update model at the rising edge, compare 1 ns later.
    task automatic step(input logic s, input logic e, input logic ch,
                        input logic [DV-1:0] vi, input logic [DC-1:0] ci);
        logic [DV-1:0] pv;
        @(negedge clk);
        start = s; iter_en = e; chan_bit = ch; vn_in = vi; cn_in = ci;
        @(posedge clk);
        pv = m_vn;
        if (s) begin
            m_ch = ch; m_vn = {DV{ch}}; m_dec = ch;
        end else if (e) begin
            for (int k = 0; k < DV; k++) m_vn[k] = ref_edge(vi, k, m_ch);
            m_dec = ref_vote(vi, m_ch);
        end
        if (s || e) m_cn = ref_parity(ci);
        #1;
        for (int k = 0; k < DV; k++)
            check(s ? (e ? "R9" : "R2") : (e ? edge_tag(vi, k) : "R8"),
                  8'(vn_out[k]), 8'(m_vn[k]));
        check(s ? "R2" : (e ? "R6" : "R8"), 8'(vn_decision), 8'(m_dec));
        check((s || e) ? "R7" : "R8", 8'(cn_out), 8'(m_cn));
        if (!s && !e) check("R8 vn unchanged", 8'(vn_out), 8'(pv));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; start = 1'b0; iter_en = 1'b0;
        @(posedge clk); #1;
        m_ch = 1'b0; m_vn = '0; m_dec = 1'b0; m_cn = '0;
        check("R1 vn_out", 8'(vn_out), 8'h0);
        check("R1 decision", 8'(vn_decision), 8'h0);
        check("R1 cn_out", 8'(cn_out), 8'h0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        do_reset();

        for (int i = 0; i < 16; i++)
            step(VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8:6], VEC[i][5:0]);

        // R10: channel pin changes after start must not reach the fallback.
        step(1'b1, 1'b0, 1'b1, 3'b000, 6'b000000);
        step(1'b0, 1'b1, 1'b0, 3'b010, 6'b000011);
        check("R10 fallback uses stored bit", 8'(vn_out[0]), 8'h1);
        // R6 tie: two ones plus stored 1 gives 3 of 4; one one plus stored 1 ties at 2.
        step(1'b0, 1'b1, 1'b0, 3'b001, 6'b000000);
        check("R6 tie goes to stored channel", 8'(vn_decision), 8'h1);
        // R9: both controls high.
        step(1'b1, 1'b1, 1'b0, 3'b111, 6'b111111);
        check("R9 start wins", 8'(vn_out), 8'h0);

        // Random traffic against the model.
        for (int i = 0; i < 300; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0] & r[1] & r[2], r[3] | r[4], r[5], r[8:6], r[14:9]);
        end

        // R1 mid-run reset after outputs have been set.
        step(1'b1, 1'b0, 1'b1, 3'b000, 6'b000001);
        do_reset();
        step(1'b0, 1'b0, 1'b1, 3'b111, 6'b111111);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule